// File: doc/BRIEF.md
# Clock Stop Gate with Full-Pulse Restart

This block passes one free-running source clock to a pair of outputs, one true and one inverted, and can park them on request. The request comes in on an active-low pin that may change at any moment, with no relation to the clock. It is brought into the clock's falling-edge domain through a short flop chain. A gate enable is then updated only while the source clock is low, so the gated output can never show a clipped high phase, whether it is stopping or restarting.

A mode strap is read once, on the first rising edge after reset is released. A low strap arms the stop feature. A high strap makes the block ignore the request pin until the next reset. A status output reports when the gated clock has actually been held low for a rising edge of the source.

Top module: `clkpark_top`

## Requirements
- R1: With the stop feature armed, holding stop_n low stops clk_t: once the latency window has passed, clk_t shows no rising edges.
- R2: While the clock is stopped, clk_t rests at 0 and clk_c rests at 1.
- R3: Every high pulse on clk_t lasts one full high phase of clk_src. This includes the last pulse before a stop and the first pulse after a restart.
- R4: After stop_n falls, clk_t produces no rising edge later than 4 clk_src cycles afterwards.
- R5: After stop_n rises, the first rising edge of clk_t arrives within 4 clk_src cycles.
- R6: mode_strap is sampled on the first rising edge of clk_src after rst falls. The sampled value holds until the next reset, so later changes of mode_strap have no effect.
- R7: If mode_strap was sampled high, stop_n is ignored: clk_t keeps pulsing every cycle and parked stays 0.
- R8: While the clock runs, clk_c is the inverse of clk_t at every point of both clock phases.
- R9: parked goes to 1 on the first rising edge of clk_src at which clk_t stays low. It returns to 0 on the rising edge at which clk_t resumes.
- R10: During reset and right after it, clk_t follows clk_src and parked is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Free-running source clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_n | input | 1 | Asynchronous stop request, active low |
| mode_strap | input | 1 | Mode strap; a low value sampled after reset arms the stop feature |
| clk_t | output | 1 | Gated clock, true phase |
| clk_c | output | 1 | Gated clock, complement phase |
| parked | output | 1 | High while the gated clock is held low |

## Verification
The stop request is changed part-way through a high phase of the source, so the gate has to wait through its synchronizer before it acts. The edges of clk_t are counted against windows of 4 cycles to bound the on and off latency, and every high pulse is timed to catch a clipped first or last pulse. A strap sampled low is compared with a strap sampled high, each under the same stop pattern, which separates the armed mode from the bypass mode. A strap that is toggled after sampling shows whether the value was latched or is followed live.

// File: rtl/clkpark_pkg.sv
`timescale 1ns/1ps
package clkpark_pkg;

    // Gate state held in the falling-edge domain
    typedef enum logic {
        GATE_RUN  = 1'b0,
        GATE_PARK = 1'b1
    } gate_state_e;

    // Strap capture register
    typedef struct packed {
        logic taken;   // strap has been sampled since reset
        logic level;   // sampled strap value
    } strap_reg_t;

    // Default synchronizer depth
    localparam int SYNC_DEPTH_DEF = 2;

    // Decide whether the gate should park
    function automatic logic park_wanted(input logic armed, input logic req_sync_n);
        return armed & ~req_sync_n;
    endfunction

endpackage

// File: rtl/clkpark_strap.sv
`timescale 1ns/1ps
module clkpark_strap
    import clkpark_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strap_in,
    output logic stop_armed
);

    strap_reg_t strap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= '{taken: 1'b0, level: 1'b1};
        end else if (!strap_q.taken) begin
            strap_q <= '{taken: 1'b1, level: strap_in};
        end
    end

    assign stop_armed = strap_q.taken & ~strap_q.level;

    // R6
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        strap_q.taken |=> $stable(strap_q.level));

    // R6
    strap_taken_chk: assert property (@(posedge clk) disable iff (rst)
        !strap_q.taken |=> strap_q.taken);

endmodule

// File: rtl/clkpark_sync.sv
`timescale 1ns/1ps
module clkpark_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // The first stage samples the asynchronous input; each later stage copies the one before it.
    // All stages are clocked on the falling edge, so the output changes only while clk is low.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(negedge clk) begin
                    if (rst) chain_q[g] <= RST_VAL;
                    else     chain_q[g] <= async_in;
                end
            end else begin : g_tail
                always_ff @(negedge clk) begin
                    if (rst) chain_q[g] <= RST_VAL;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/clkpark_ctrl.sv
`timescale 1ns/1ps
module clkpark_ctrl
    import clkpark_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_armed,
    input  logic req_sync_n,
    input  logic req_raw_n,
    output logic gate_en,
    output logic parked
);

    // Worst-case delay is the synchronizer depth plus the state flop, and it stays below this bound
    localparam int LAT_LIMIT = SYNC_STAGES + 2;
    localparam int LAG_W     = $clog2(LAT_LIMIT + 1);

    gate_state_e state_q;
    logic        parked_q;

    always_ff @(negedge clk) begin
        if (rst) state_q <= GATE_RUN;
        else     state_q <= park_wanted(stop_armed, req_sync_n) ? GATE_PARK : GATE_RUN;
    end

    assign gate_en = (state_q == GATE_RUN);

    // Status: set once a rising edge of the source has been suppressed
    always_ff @(posedge clk) begin
        if (rst) parked_q <= 1'b0;
        else     parked_q <= ~gate_en;
    end

    assign parked = parked_q;

    // Latency watch: counts falling edges during which the enable disagrees with the raw request
    logic             want_run;
    logic [LAG_W-1:0] lag_q;

    assign want_run = ~(stop_armed & ~req_raw_n);

    always_ff @(negedge clk) begin
        if (rst)                      lag_q <= '0;
        else if (want_run == gate_en) lag_q <= '0;
        else if (lag_q != '1)         lag_q <= lag_q + 1'b1;
    end

    // R4 R5
    lat_bound_chk: assert property (@(negedge clk) disable iff (rst)
        lag_q < LAG_W'(LAT_LIMIT));

    // R7
    bypass_run_chk: assert property (@(negedge clk) disable iff (rst)
        !stop_armed |=> gate_en);

    // R9
    park_set_chk: assert property (@(posedge clk) disable iff (rst)
        !gate_en |=> parked_q);

    // R9
    park_clr_chk: assert property (@(posedge clk) disable iff (rst)
        gate_en |=> !parked_q);

endmodule

// File: rtl/clkpark_top.sv
`timescale 1ns/1ps
module clkpark_top
    import clkpark_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH_DEF
) (
    input  logic clk_src,
    input  logic rst,
    input  logic stop_n,
    input  logic mode_strap,
    output logic clk_t,
    output logic clk_c,
    output logic parked
);

    logic stop_armed;
    logic req_sync_n;
    logic gate_en;

    clkpark_strap u_strap (
        .clk        (clk_src),
        .rst        (rst),
        .strap_in   (mode_strap),
        .stop_armed (stop_armed)
    );

    clkpark_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk      (clk_src),
        .rst      (rst),
        .async_in (stop_n),
        .sync_out (req_sync_n)
    );

    clkpark_ctrl #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ctrl (
        .clk        (clk_src),
        .rst        (rst),
        .stop_armed (stop_armed),
        .req_sync_n (req_sync_n),
        .req_raw_n  (stop_n),
        .gate_en    (gate_en),
        .parked     (parked)
    );

    // The enable only changes on the falling edge, so both gates see it change while clk_src is low
    assign clk_t = clk_src & gate_en;
    assign clk_c = ~(clk_src & gate_en);

    // R2
    park_low_chk: assert property (@(negedge clk_src) disable iff (rst)
        parked |-> (!clk_t && clk_c));

endmodule

// File: tb/clkpark_top_test.sv
`timescale 1ns/1ps
module clkpark_top_test;

    logic clk_src = 1'b0;
    logic rst = 1'b1;
    logic stop_n = 1'b1;
    logic mode_strap = 1'b0;
    logic clk_t, clk_c, parked;

    int checks = 0;
    int errors = 0;

    clkpark_top uut (
        .clk_src    (clk_src),
        .rst        (rst),
        .stop_n     (stop_n),
        .mode_strap (mode_strap),
        .clk_t      (clk_t),
        .clk_c      (clk_c),
        .parked     (parked)
    );

    always #2.5 clk_src = ~clk_src;

    // Monotonic monitors: rising edges of clk_t, and high pulses of the wrong width
    int      rise_total = 0;
    int      bad_pulses = 0;
    int      good_pulses = 0;
    realtime t_rise = 0.0;
    realtime last_w = 0.0;

    always @(posedge clk_t) begin
        rise_total++;
        t_rise = $realtime;
    end

    always @(negedge clk_t) begin
        last_w = $realtime - t_rise;
        if (last_w > 2.4 && last_w < 2.6) good_pulses++;
        else                              bad_pulses++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1;
        stop_n = 1'b1;
        mode_strap = strap;
        repeat (4) @(posedge clk_src);
        #1 rst = 1'b0;
        @(posedge clk_src);
        #1;
    endtask

    task automatic t_reset_state();
        int base;
        rst = 1'b1;
        repeat (3) @(posedge clk_src);
        #1;
        check(parked == 1'b0, "R10 parked in reset", parked, 0);
        base = rise_total;
        repeat (2) @(posedge clk_src);
        #1;
        check(rise_total - base == 2, "R10 clk_t runs in reset", rise_total - base, 2);
        do_reset(1'b0);
        check(parked == 1'b0, "R10 parked after reset", parked, 0);
        base = rise_total;
        repeat (8) @(posedge clk_src);
        #1;
        check(rise_total - base == 8, "R10 clk_t runs after reset", rise_total - base, 8);
    endtask

    task automatic t_complement();
        @(posedge clk_src);
        #1;
        check(clk_t == 1'b1 && clk_c == 1'b0, "R8 high phase", {clk_t, clk_c}, 2);
        #2.5;
        check(clk_t == 1'b0 && clk_c == 1'b1, "R8 low phase", {clk_t, clk_c}, 1);
    endtask

    task automatic t_stop();
        int base;
        int bad0;
        bad0 = bad_pulses;
        @(posedge clk_src);
        #1;
        base = rise_total;
        stop_n = 1'b0;
        repeat (4) @(posedge clk_src);
        #1;
        check(rise_total - base <= 3, "R4 off latency", rise_total - base, 3);
        base = rise_total;
        repeat (6) @(posedge clk_src);
        #1;
        check(rise_total - base == 0, "R1 stopped", rise_total - base, 0);
        check(clk_t == 1'b0 && clk_c == 1'b1, "R2 rest levels", {clk_t, clk_c}, 1);
        check(parked == 1'b1, "R9 parked set", parked, 1);
        check(bad_pulses == bad0, "R3 last pulse width", bad_pulses - bad0, 0);
    endtask

    task automatic t_restart();
        int base;
        int bad0;
        int good0;
        bad0 = bad_pulses;
        good0 = good_pulses;
        @(posedge clk_src);
        #1;
        base = rise_total;
        stop_n = 1'b1;
        @(posedge clk_t);
        #1;
        check(parked == 1'b0, "R9 parked cleared at resume", parked, 0);
        repeat (3) @(posedge clk_src);
        #1;
        check(rise_total - base >= 1, "R5 on latency", rise_total - base, 1);
        check(bad_pulses == bad0 && good_pulses > good0, "R3 first pulse width",
              bad_pulses - bad0, 0);
    endtask

    task automatic t_restart_latency();
        int base;
        @(posedge clk_src);
        #1;
        stop_n = 1'b0;
        repeat (8) @(posedge clk_src);
        #1;
        base = rise_total;
        stop_n = 1'b1;
        repeat (4) @(posedge clk_src);
        #0.5;
        check(rise_total - base >= 1, "R5 resume inside 4 cycles", rise_total - base, 1);
        repeat (2) @(posedge clk_src);
        #1;
    endtask

    task automatic t_strap_high();
        int base;
        do_reset(1'b1);
        base = rise_total;
        stop_n = 1'b0;
        repeat (8) @(posedge clk_src);
        #1;
        check(rise_total - base == 8, "R7 stop ignored", rise_total - base, 8);
        check(parked == 1'b0, "R7 parked stays low", parked, 0);
        stop_n = 1'b1;
    endtask

    task automatic t_strap_latched();
        int base;
        do_reset(1'b0);
        mode_strap = 1'b1;
        stop_n = 1'b0;
        repeat (5) @(posedge clk_src);
        #1;
        base = rise_total;
        repeat (5) @(posedge clk_src);
        #1;
        check(rise_total - base == 0, "R6 low strap held", rise_total - base, 0);
        do_reset(1'b1);
        mode_strap = 1'b0;
        base = rise_total;
        stop_n = 1'b0;
        repeat (8) @(posedge clk_src);
        #1;
        check(rise_total - base == 8, "R6 high strap held", rise_total - base, 8);
        stop_n = 1'b1;
    endtask

    initial begin
        t_reset_state();
        t_complement();
        t_stop();
        t_restart();
        t_complement();
        t_restart_latency();
        t_strap_high();
        t_strap_latched();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule